// File: doc/BRIEF.md
# Cascaded reset controller

This block builds the chip's tree of active-low resets. A single root reset, the power-on input or, while scan mode is on, the scan reset, feeds an always-on reset that is held until the power-good input has been high for a fixed run of cycles. Below it sit the life-cycle reset, the system reset and one reset for each peripheral, in that order. Each level is held whenever its parent is held. Each level can also be pulled down by its own request: the power manager's life-cycle and system requests, the debug module's request to reset everything except itself, and a software control bit for each peripheral.

Every derived reset asserts asynchronously, as soon as its source goes low. It is released synchronously through a two-flop stage clocked by `clk_i`, which stands in for the clock of each reset domain. Software reaches the peripheral control bits through a small register-write port. A per-peripheral write-enable bit can lock each control bit until the next system reset. A companion vector tells the alert handler which domains are currently in reset.

The register port follows valid/ready rules. A write is taken on a rising edge where `reg_valid_i` and `reg_ready_o` are both high. `reg_ready_o` is low for as long as the system reset is asserted. While ready is low, the writer must hold its request, and a write presented during that time is not taken.

Top module: `cascade_reset_ctrl`

## Requirements
- R1: After the root reset is released and has passed its own two-flop release stage, `rst_por_no` goes high just after the 32nd consecutive rising edge at which `pwr_good_i` is sampled high. Before that it stays low.
- R2: A rising edge that samples `pwr_good_i` low clears the run count. If `rst_por_no` was high, it goes low right after that edge and every derived reset follows it.
- R3: While `scan_mode_i` is high, a low `scan_rst_ni` asserts every reset output at once, with no clock edge needed. While `scan_mode_i` is low, `scan_rst_ni` has no effect.
- R4: A derived reset is never high while its parent is low. The order is power-on, then life-cycle, then system, then each peripheral. Each level is released on the second rising edge after its source goes high.
- R5: A high `lc_rst_req_i` asserts the life-cycle, system and all peripheral resets at once. `rst_por_no` is not affected.
- R6: A high `sys_rst_req_i` asserts the system reset and all peripheral resets at once. The life-cycle and power-on resets are not affected.
- R7: A high `dbg_rst_req_i` has the same effect as a system reset request.
- R8: A write to offset 0 loads the active-low peripheral control bits (bit i controls peripheral i). Writing 0 to a bit asserts `rst_periph_no[i]` right after the write edge. Writing 1 releases it two edges later. Other peripherals are not affected.
- R9: A write to offset 4 clears each write-enable bit written with 1. Bits written with 0 stay as they are. While write-enable bit i is 0, writes to control bit i are ignored. A system reset sets all write-enable bits back to 1.
- R10: `alert_rst_en_o` is high for each reset that is asserted. Bit 0 is power-on, bit 1 life-cycle, bit 2 system, and bit 3+i is peripheral i.
- R11: `reg_ready_o` is high exactly when `rst_sys_no` is high. A write presented while it is low is not taken.
- R12: While the root reset is held, all reset outputs are low and `alert_rst_en_o` is all ones. When the system reset releases, all control bits and all write-enable bits read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock used by every reset domain |
| por_ni | input | 1 | Power-on reset, active low, asynchronous |
| pwr_good_i | input | 1 | Always-on power-good indication |
| scan_mode_i | input | 1 | Scan mode; selects `scan_rst_ni` as the root reset |
| scan_rst_ni | input | 1 | Scan reset, active low |
| lc_rst_req_i | input | 1 | Life-cycle reset request from the power manager |
| sys_rst_req_i | input | 1 | System reset request from the power manager |
| dbg_rst_req_i | input | 1 | Debug request to reset everything except the debug module |
| reg_valid_i | input | 1 | Register write request |
| reg_ready_o | output | 1 | Register port can accept a write |
| reg_addr_i | input | ADDR_W | Register byte offset (0 control, 4 write-enable) |
| reg_wdata_i | input | NUM_PERIPH | Register write data |
| rst_por_no | output | 1 | Always-on power-on reset, active low |
| rst_lc_no | output | 1 | Life-cycle reset, active low |
| rst_sys_no | output | 1 | System reset, active low |
| rst_periph_no | output | NUM_PERIPH | Peripheral resets, active low |
| alert_rst_en_o | output | NUM_PERIPH+3 | Per-reset "in reset" flags for the alert handler |

## Verification
The bench aims at the exact edge where the power-good count completes. A count that is off by one would release `rst_por_no` one cycle early or late. A power-good glitch partway through the count is also targeted, which catches a design that pauses its count instead of restarting it. The release order is checked edge by edge. A design that skips a synchronizer stage, or that lets a child follow the root instead of its parent, shows up as an output released too soon. The lock tests write zeros to the write-enable register, try writes during a system reset, and confirm that only a reset unlocks a bit. These tests catch a write-enable with the wrong polarity and registers that keep state across a reset.

// File: rtl/cascade_rst_pkg.sv
package cascade_rst_pkg;
  // positions of the fixed levels in the alert enable vector
  localparam int unsigned LVL_POR    = 0;
  localparam int unsigned LVL_LC     = 1;
  localparam int unsigned LVL_SYS    = 2;
  localparam int unsigned LVL_PERIPH = 3;
  localparam int unsigned NUM_FIXED  = 3;

  // register byte offsets
  localparam int unsigned OFS_CTRL = 0;
  localparam int unsigned OFS_WEN  = 4;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_CTRL,
    REG_WEN
  } reg_sel_e;
endpackage

// File: rtl/crc_reset_sync.sv
module crc_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) pipe_q <= 1'b0;
        else          pipe_q <= 1'b1;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) pipe_q <= '0;
        else          pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/crc_por_stretch.sv
module crc_por_stretch #(
  parameter int unsigned CYCLES = 32
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic en_i,
  input  logic good_i,
  output logic rel_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] run_q, run_d;

  always_comb begin
    if (!good_i || !en_i)   run_d = '0;
    else if (run_q == LIMIT) run_d = run_q;
    else                     run_d = run_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) run_q <= '0;
    else          run_q <= run_d;
  end

  assign rel_o = (run_q == LIMIT);
endmodule

// File: rtl/crc_sw_regs.sv
module crc_sw_regs
  import cascade_rst_pkg::*;
#(
  parameter int unsigned NUM_PERIPH = 4,
  parameter int unsigned ADDR_W     = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NUM_PERIPH-1:0] wdata_i,
  output logic [NUM_PERIPH-1:0] ctrl_no
);
  logic [NUM_PERIPH-1:0] ctrl_q, wen_q;
  reg_sel_e              sel;

  always_comb begin
    sel = REG_NONE;
    if (valid_i) begin
      if (addr_i == ADDR_W'(OFS_CTRL))     sel = REG_CTRL;
      else if (addr_i == ADDR_W'(OFS_WEN)) sel = REG_WEN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '1;
      wen_q  <= '1;
    end else begin
      if (sel == REG_CTRL) ctrl_q <= (ctrl_q & ~wen_q) | (wdata_i & wen_q);
      if (sel == REG_WEN)  wen_q  <= wen_q & ~wdata_i;
    end
  end

  assign ctrl_no = ctrl_q;
endmodule

// File: rtl/cascade_reset_ctrl.sv
module cascade_reset_ctrl
  import cascade_rst_pkg::*;
#(
  parameter int unsigned NUM_PERIPH     = 4,
  parameter int unsigned STRETCH_CYCLES = 32,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned ADDR_W         = 4,
  localparam int unsigned NUM_RST       = NUM_FIXED + NUM_PERIPH
) (
  input  logic                  clk_i,
  input  logic                  por_ni,
  input  logic                  pwr_good_i,
  input  logic                  scan_mode_i,
  input  logic                  scan_rst_ni,
  input  logic                  lc_rst_req_i,
  input  logic                  sys_rst_req_i,
  input  logic                  dbg_rst_req_i,
  input  logic                  reg_valid_i,
  output logic                  reg_ready_o,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [NUM_PERIPH-1:0] reg_wdata_i,
  output logic                  rst_por_no,
  output logic                  rst_lc_no,
  output logic                  rst_sys_no,
  output logic [NUM_PERIPH-1:0] rst_periph_no,
  output logic [NUM_RST-1:0]    alert_rst_en_o
);
  logic                  root_n, root_ok_n;
  logic                  por_n, lc_src_n, lc_n, sys_src_n, sys_n;
  logic [NUM_PERIPH-1:0] ctrl_n, periph_n;

  // root: scan reset replaces the power-on input while scan mode is on
  assign root_n = scan_mode_i ? scan_rst_ni : por_ni;

  crc_reset_sync #(.STAGES(SYNC_STAGES)) u_root_sync (
    .clk_i   (clk_i),
    .arst_ni (root_n),
    .rst_no  (root_ok_n)
  );

  crc_por_stretch #(.CYCLES(STRETCH_CYCLES)) u_stretch (
    .clk_i   (clk_i),
    .arst_ni (root_n),
    .en_i    (root_ok_n),
    .good_i  (pwr_good_i),
    .rel_o   (por_n)
  );

  assign lc_src_n = por_n & ~lc_rst_req_i;

  crc_reset_sync #(.STAGES(SYNC_STAGES)) u_lc_sync (
    .clk_i   (clk_i),
    .arst_ni (lc_src_n),
    .rst_no  (lc_n)
  );

  assign sys_src_n = lc_n & ~sys_rst_req_i & ~dbg_rst_req_i;

  crc_reset_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (
    .clk_i   (clk_i),
    .arst_ni (sys_src_n),
    .rst_no  (sys_n)
  );

  crc_sw_regs #(.NUM_PERIPH(NUM_PERIPH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (sys_n),
    .valid_i (reg_valid_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .ctrl_no (ctrl_n)
  );

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
    logic src_n;
    assign src_n = sys_n & ctrl_n[p];
    crc_reset_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .arst_ni (src_n),
      .rst_no  (periph_n[p])
    );
  end

  assign rst_por_no     = por_n;
  assign rst_lc_no      = lc_n;
  assign rst_sys_no     = sys_n;
  assign rst_periph_no  = periph_n;
  assign reg_ready_o    = sys_n;
  assign alert_rst_en_o = ~{periph_n, sys_n, lc_n, por_n};
endmodule

// File: rtl/cascade_reset_ctrl_chk.sv
module cascade_reset_ctrl_chk #(
  parameter int unsigned NUM_PERIPH     = 4,
  parameter int unsigned STRETCH_CYCLES = 32
) (
  input logic                  clk_i,
  input logic                  por_ni,
  input logic                  pwr_good_i,
  input logic                  scan_mode_i,
  input logic                  scan_rst_ni,
  input logic                  lc_rst_req_i,
  input logic                  sys_rst_req_i,
  input logic                  dbg_rst_req_i,
  input logic                  rst_por_no,
  input logic                  rst_lc_no,
  input logic                  rst_sys_no,
  input logic [NUM_PERIPH-1:0] rst_periph_no
);
  localparam int unsigned RW = $clog2(STRETCH_CYCLES + 1) + 1;
  localparam logic [RW-1:0] RMAX = '1;

  logic          root_n;
  logic [RW-1:0] good_run;

  assign root_n = scan_mode_i ? scan_rst_ni : por_ni;

  // independent count of consecutive power-good samples since root release
  always_ff @(posedge clk_i or negedge root_n) begin
    if (!root_n)                 good_run <= '0;
    else if (!pwr_good_i)        good_run <= '0;
    else if (good_run != RMAX)   good_run <= good_run + 1'b1;
  end

  // R1
  por_min_run_chk: assert property (@(posedge clk_i) disable iff (!root_n)
    rst_por_no |-> (good_run >= RW'(STRETCH_CYCLES)));

  // R2
  good_drop_chk: assert property (@(posedge clk_i) disable iff (!root_n)
    !pwr_good_i |=> !rst_por_no);

  // R4
  lc_under_por_chk: assert property (@(posedge clk_i) disable iff (!root_n)
    rst_lc_no |-> rst_por_no);

  // R4
  sys_under_lc_chk: assert property (@(posedge clk_i) disable iff (!root_n)
    rst_sys_no |-> rst_lc_no);

  for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_chk
    // R4
    periph_under_sys_chk: assert property (@(posedge clk_i) disable iff (!root_n)
      rst_periph_no[p] |-> rst_sys_no);
  end

  // R5
  lc_req_chk: assert property (@(posedge clk_i) disable iff (!root_n)
    lc_rst_req_i |-> !rst_lc_no);

  // R6
  sys_req_chk: assert property (@(posedge clk_i) disable iff (!root_n)
    sys_rst_req_i |-> !rst_sys_no);

  // R7
  dbg_req_chk: assert property (@(posedge clk_i) disable iff (!root_n)
    dbg_rst_req_i |-> !rst_sys_no);
endmodule

bind cascade_reset_ctrl cascade_reset_ctrl_chk #(
  .NUM_PERIPH     (NUM_PERIPH),
  .STRETCH_CYCLES (STRETCH_CYCLES)
) u_chk (
  .clk_i         (clk_i),
  .por_ni        (por_ni),
  .pwr_good_i    (pwr_good_i),
  .scan_mode_i   (scan_mode_i),
  .scan_rst_ni   (scan_rst_ni),
  .lc_rst_req_i  (lc_rst_req_i),
  .sys_rst_req_i (sys_rst_req_i),
  .dbg_rst_req_i (dbg_rst_req_i),
  .rst_por_no    (rst_por_no),
  .rst_lc_no     (rst_lc_no),
  .rst_sys_no    (rst_sys_no),
  .rst_periph_no (rst_periph_no)
);

// File: tb/cascade_reset_ctrl_tb.sv
module cascade_reset_ctrl_tb;
  localparam int unsigned NP = 4;
  localparam int unsigned NR = NP + 3;

  logic          clk = 1'b0;
  logic          por_ni = 1'b0, pwr_good_i = 1'b0;
  logic          scan_mode_i = 1'b0, scan_rst_ni = 1'b1;
  logic          lc_rst_req_i = 1'b0, sys_rst_req_i = 1'b0, dbg_rst_req_i = 1'b0;
  logic          reg_valid_i = 1'b0;
  logic          reg_ready_o;
  logic [3:0]    reg_addr_i = '0;
  logic [NP-1:0] reg_wdata_i = '0;
  logic          rst_por_no, rst_lc_no, rst_sys_no;
  logic [NP-1:0] rst_periph_no;
  logic [NR-1:0] alert_rst_en_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  cascade_reset_ctrl u_dut (
    .clk_i          (clk),
    .por_ni         (por_ni),
    .pwr_good_i     (pwr_good_i),
    .scan_mode_i    (scan_mode_i),
    .scan_rst_ni    (scan_rst_ni),
    .lc_rst_req_i   (lc_rst_req_i),
    .sys_rst_req_i  (sys_rst_req_i),
    .dbg_rst_req_i  (dbg_rst_req_i),
    .reg_valid_i    (reg_valid_i),
    .reg_ready_o    (reg_ready_o),
    .reg_addr_i     (reg_addr_i),
    .reg_wdata_i    (reg_wdata_i),
    .rst_por_no     (rst_por_no),
    .rst_lc_no      (rst_lc_no),
    .rst_sys_no     (rst_sys_no),
    .rst_periph_no  (rst_periph_no),
    .alert_rst_en_o (alert_rst_en_o)
  );

  function automatic logic [NR-1:0] status();
    return {rst_periph_no, rst_sys_no, rst_lc_no, rst_por_no};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [3:0] addr, input logic [NP-1:0] data);
    @(negedge clk);
    reg_valid_i = 1'b1;
    reg_addr_i  = addr;
    reg_wdata_i = data;
    @(negedge clk);
    reg_valid_i = 1'b0;
  endtask

  task automatic bring_up();
    @(negedge clk);
    scan_mode_i = 1'b0;
    por_ni      = 1'b0;
    pwr_good_i  = 1'b0;
    edges(3);
    por_ni     = 1'b1;
    pwr_good_i = 1'b1;
    edges(45);
  endtask

  // R12 R10: reset state while the root is held
  task automatic t_reset_state();
    edges(3);
    check("R12 outputs in reset", 32'(status()), 32'h0);
    check("R10 alert all ones", 32'(alert_rst_en_o), 32'h7f);
    check("R11 ready low in reset", 32'(reg_ready_o), 32'h0);
  endtask

  // R1 R4: exact stretch length and release order
  task automatic t_stretch();
    por_ni = 1'b1;
    edges(5);
    check("R1 held without power good", 32'(rst_por_no), 32'h0);
    pwr_good_i = 1'b1;
    edges(31);
    check("R1 held after 31 good edges", 32'(rst_por_no), 32'h0);
    edges(1);
    check("R1 released after 32 good edges", 32'(status()), 32'h01);
    edges(1);
    check("R4 lc held one edge", 32'(rst_lc_no), 32'h0);
    edges(1);
    check("R4 lc released second edge", 32'(status()), 32'h03);
    edges(1);
    check("R4 sys held one edge", 32'(rst_sys_no), 32'h0);
    edges(1);
    check("R4 sys released", 32'(status()), 32'h07);
    check("R11 ready follows sys", 32'(reg_ready_o), 32'h1);
    edges(1);
    check("R4 periph held one edge", 32'(rst_periph_no), 32'h0);
    edges(1);
    check("R4 all released", 32'(status()), 32'h7f);
    check("R10 alert all clear", 32'(alert_rst_en_o), 32'h0);
  endtask

  // R2: glitch restarts the count; drop after release re-asserts
  task automatic t_glitch();
    @(negedge clk);
    por_ni = 1'b0; pwr_good_i = 1'b0;
    edges(2);
    por_ni = 1'b1;
    edges(5);
    pwr_good_i = 1'b1;
    edges(20);
    pwr_good_i = 1'b0;
    edges(1);
    pwr_good_i = 1'b1;
    edges(31);
    check("R2 count restarted", 32'(rst_por_no), 32'h0);
    edges(1);
    check("R2 release after full new run", 32'(rst_por_no), 32'h1);
    edges(10);
    check("R2 tree up", 32'(status()), 32'h7f);
    pwr_good_i = 1'b0;
    edges(1);
    pwr_good_i = 1'b1;
    check("R2 drop re-asserts all", 32'(status()), 32'h0);
    check("R10 alert after drop", 32'(alert_rst_en_o), 32'h7f);
    edges(45);
    check("R2 recovered", 32'(status()), 32'h7f);
  endtask

  // R5: life-cycle request
  task automatic t_lc_req();
    @(negedge clk);
    lc_rst_req_i = 1'b1;
    #1;
    check("R5 lc request asserts lc and below", 32'(status()), 32'h01);
    check("R10 alert during lc request", 32'(alert_rst_en_o), 32'h7e);
    edges(2);
    lc_rst_req_i = 1'b0;
    edges(1);
    check("R4 lc held one edge after request", 32'(rst_lc_no), 32'h0);
    edges(1);
    check("R4 lc release", 32'(status()), 32'h03);
    edges(2);
    check("R4 sys release after lc", 32'(status()), 32'h07);
    edges(2);
    check("R5 recovered", 32'(status()), 32'h7f);
  endtask

  // R6 R7: system and debug requests
  task automatic t_sys_req(input bit use_dbg);
    @(negedge clk);
    if (use_dbg) dbg_rst_req_i = 1'b1;
    else         sys_rst_req_i = 1'b1;
    #1;
    if (use_dbg) check("R7 debug request asserts sys and below", 32'(status()), 32'h03);
    else         check("R6 sys request asserts sys and below", 32'(status()), 32'h03);
    check("R11 ready low during sys reset", 32'(reg_ready_o), 32'h0);
    edges(2);
    dbg_rst_req_i = 1'b0;
    sys_rst_req_i = 1'b0;
    edges(2);
    check(use_dbg ? "R7 sys release" : "R6 sys release", 32'(status()), 32'h07);
    edges(2);
    check(use_dbg ? "R7 recovered" : "R6 recovered", 32'(status()), 32'h7f);
  endtask

  // R8: software peripheral control
  task automatic t_sw();
    reg_write(4'd0, 4'b1101);
    check("R8 periph 1 asserted after write", 32'(status()), 32'h6f);
    reg_write(4'd0, 4'b1111);
    check("R8 periph 1 held at write edge", 32'(rst_periph_no), 32'hd);
    edges(1);
    check("R8 periph 1 held one edge", 32'(rst_periph_no), 32'hd);
    edges(1);
    check("R8 periph 1 released", 32'(rst_periph_no), 32'hf);
  endtask

  // R9 R11: write-enable lock and its reset
  task automatic t_lock();
    reg_write(4'd4, 4'b0010);
    reg_write(4'd0, 4'b0000);
    check("R9 locked bit kept", 32'(rst_periph_no), 32'h2);
    reg_write(4'd4, 4'b0000);
    reg_write(4'd0, 4'b1111);
    edges(2);
    check("R9 unlocked bits writable", 32'(rst_periph_no), 32'hf);
    reg_write(4'd0, 4'b0000);
    check("R9 zero write to enable has no effect", 32'(rst_periph_no), 32'h2);
    @(negedge clk);
    sys_rst_req_i = 1'b1;
    reg_write(4'd4, 4'b1111);
    check("R11 ready low while sys held", 32'(reg_ready_o), 32'h0);
    @(negedge clk);
    sys_rst_req_i = 1'b0;
    edges(4);
    check("R12 control bits back to one", 32'(status()), 32'h7f);
    reg_write(4'd0, 4'b1101);
    check("R9 enable restored by reset", 32'(rst_periph_no), 32'hd);
    reg_write(4'd0, 4'b0111);
    check("R11 enable write during reset not taken", 32'(rst_periph_no), 32'h5);
    reg_write(4'd0, 4'b1111);
    edges(2);
    check("R9 tree up", 32'(status()), 32'h7f);
  endtask

  // R3: scan reset qualification
  task automatic t_scan();
    @(negedge clk);
    scan_rst_ni = 1'b0;
    edges(3);
    check("R3 scan reset ignored outside scan", 32'(status()), 32'h7f);
    scan_mode_i = 1'b1;
    #1;
    check("R3 scan reset asserts all", 32'(status()), 32'h0);
    check("R10 alert in scan reset", 32'(alert_rst_en_o), 32'h7f);
    @(negedge clk);
    scan_rst_ni = 1'b1;
    scan_mode_i = 1'b0;
    edges(45);
    check("R3 recovered after scan", 32'(status()), 32'h7f);
  endtask

  initial begin
    t_reset_state();
    t_stretch();
    t_glitch();
    t_lc_req();
    t_sys_req(1'b0);
    t_sys_req(1'b1);
    t_sw();
    t_lock();
    t_scan();
    bring_up();
    check("R12 bring up again", 32'(status()), 32'h7f);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R1..: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule